// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single reservation that a load-linked / store-conditional pair relies on, so that software can build an atomic read-modify-write out of two ordinary memory instructions. A load-linked request arms the reservation with its word address. A later store-conditional to the same word succeeds only if nothing has happened in between that could break atomicity. On success it returns 1 to its destination register and is allowed to write memory. On failure it returns 0 and memory is left untouched.

The monitor watches the local pipeline's request stream, a snoop port that reports stores made by other agents, an exception strobe and a context-switch strobe. The reservation is dropped by any local store, by a store from elsewhere to the reserved word, by an exception, by a context switch and by every store-conditional. Register-to-register work between the two instructions leaves it intact. The store-conditional's answer is combinational in the cycle the request is presented. Reservation changes take effect at the next rising clock edge.

Top module: `resv_monitor`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears the reservation, so a store-conditional issued after reset, with no load-linked since, fails with `sc_pass_o`=0 and `sc_we_o`=0.
- R2: A load-linked (`op_i`=2'b01) arms the reservation from the next clock edge. A store-conditional (`op_i`=2'b10) to the same word, with no intervening disturbance, drives `sc_pass_o`=1 and `sc_we_o`=1 in its own request cycle.
- R3: A store-conditional whose word address differs from the reserved word fails.
- R4: Addresses are compared as words: the low 2 byte-offset bits of `addr_i` and `snoop_addr_i` are ignored.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails, so a second store-conditional right after it fails.
- R6: A local plain store (`op_i`=2'b11) to any address clears the reservation.
- R7: A snooped store (`snoop_we_i`=1) to the reserved word clears the reservation. A snooped store to any other word does not.
- R8: An exception (`exc_i`=1) clears the reservation.
- R9: A context switch (`ctx_sw_i`=1) clears the reservation.
- R10: Register-to-register cycles (`op_i`=2'b00), any number of them, neither arm nor clear the reservation.
- R11: A new load-linked replaces any earlier reservation, so a store-conditional to the earlier word then fails.
- R12: `sc_pass_o` and `sc_we_o` are 0 in every cycle that is not a store-conditional request, and `sc_we_o` always equals `sc_pass_o`.
- R13: Same-cycle events: an exception, a context switch or a matching snooped store presented with a store-conditional makes it fail. An exception or context switch presented with a load-linked prevents arming. A matching snooped store presented with a load-linked does not prevent arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Request kind: 00 register op/idle, 01 load-linked, 10 store-conditional, 11 plain store |
| addr_i | input | ADDR_W | Byte address of the request |
| snoop_we_i | input | 1 | A store by another agent is observed this cycle |
| snoop_addr_i | input | ADDR_W | Byte address of the observed store |
| exc_i | input | 1 | Exception taken this cycle |
| ctx_sw_i | input | 1 | Context switch this cycle |
| sc_pass_o | output | 1 | Store-conditional result bit (1 success, 0 failure) |
| sc_we_o | output | 1 | Memory write enable for the store-conditional |

## Verification
The pair is tried clean, with register ops between the two halves, and with each disturbing event placed between them: a local store to an unrelated address, snooped stores to the reserved word and to a neighbouring word, an exception and a context switch. Each pattern separates one clearing source from the others. Address pairs that differ only in the byte offset, or only in one word bit, show whether the comparison is made at word granularity. Back-to-back store-conditionals, re-armed load-linked sequences and events that coincide with either half of the pair pin down the priority between arming and clearing.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_ALU = 2'b00,
    OP_LL  = 2'b01,
    OP_SC  = 2'b10,
    OP_ST  = 2'b11
  } resv_op_e;

  // Both store forms end any reservation held by this hart
  function automatic logic writes_memory(input resv_op_e op);
    return (op == OP_SC) || (op == OP_ST);
  endfunction

endpackage

// File: rtl/resv_word_cmp.sv
module resv_word_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 2
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-OFFS_W-1:0] word,
  output logic                     same
);

  // Drop the byte offset, then compare at full width
  function automatic logic [ADDR_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a >> OFFS_W;
  endfunction

  assign same = (word_index(addr) == ADDR_W'(word));

endmodule

// File: rtl/resv_event_ctl.sv
module resv_event_ctl
  import resv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  resv_op_e op,
  input  logic     exc,
  input  logic     ctx_sw,
  input  logic     snoop_we,
  input  logic     snoop_hit,
  input  logic     req_hit,
  input  logic     resv_valid,
  output logic     take_ll,
  output logic     drop,
  output logic     sc_ok
);

  logic flush_w;
  logic snoop_kill_w;

  assign flush_w      = exc | ctx_sw;
  assign snoop_kill_w = snoop_we & snoop_hit;

  assign take_ll = (op == OP_LL) & ~flush_w;
  assign drop    = flush_w | writes_memory(op) | snoop_kill_w;
  assign sc_ok   = (op == OP_SC) & resv_valid & req_hit & ~flush_w & ~snoop_kill_w;

  // R10: a quiet register op is invisible to the reservation
  a_r10_alu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ALU && !exc && !ctx_sw && !snoop_we) |-> (!drop && !take_ll));

  // R12: success only on a store-conditional
  a_r12_ok_only_sc: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> (op == OP_SC));

endmodule

// File: rtl/resv_state.sv
module resv_state #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_ll,
  input  logic                     drop,
  input  logic [ADDR_W-1:0]        ll_addr,
  output logic                     valid_q,
  output logic [ADDR_W-OFFS_W-1:0] word_q
);

  localparam int WORD_W = ADDR_W - OFFS_W;

  function automatic logic [WORD_W-1:0] to_word(input logic [ADDR_W-1:0] a);
    return WORD_W'(a >> OFFS_W);
  endfunction

  // Arming wins over every clear source that can coincide with it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (take_ll) begin
      valid_q <= 1'b1;
      word_q  <= to_word(ll_addr);
    end else if (drop) begin
      valid_q <= 1'b0;
    end
  end

  // R2: a load-linked arms the reservation with its word
  a_r2_ll_arms: assert property (@(posedge clk) disable iff (!rst_n)
    take_ll |=> (valid_q && word_q == to_word($past(ll_addr))));

  // R5: any clear event without arming leaves nothing reserved
  a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !take_ll) |=> !valid_q);

  // R10: with no event the reservation holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!drop && !take_ll) |=> ($stable(valid_q) && $stable(word_q)));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              snoop_we_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              exc_i,
  input  logic              ctx_sw_i,
  output logic              sc_pass_o,
  output logic              sc_we_o
);

  localparam int WORD_W = ADDR_W - OFFS_W;

  resv_op_e          op_w;
  logic              resv_valid_w;
  logic [WORD_W-1:0] resv_word_w;
  logic              req_hit_w;
  logic              snoop_hit_w;
  logic              take_ll_w;
  logic              drop_w;
  logic              sc_ok_w;

  assign op_w = resv_op_e'(op_i);

  resv_word_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_req_cmp (
    .addr (addr_i),
    .word (resv_word_w),
    .same (req_hit_w)
  );

  resv_word_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_snoop_cmp (
    .addr (snoop_addr_i),
    .word (resv_word_w),
    .same (snoop_hit_w)
  );

  resv_event_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op_w),
    .exc        (exc_i),
    .ctx_sw     (ctx_sw_i),
    .snoop_we   (snoop_we_i),
    .snoop_hit  (snoop_hit_w),
    .req_hit    (req_hit_w),
    .resv_valid (resv_valid_w),
    .take_ll    (take_ll_w),
    .drop       (drop_w),
    .sc_ok      (sc_ok_w)
  );

  resv_state #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_ll (take_ll_w),
    .drop    (drop_w),
    .ll_addr (addr_i),
    .valid_q (resv_valid_w),
    .word_q  (resv_word_w)
  );

  assign sc_pass_o = sc_ok_w;
  assign sc_we_o   = sc_ok_w;

  // R3: success requires a live reservation on the requested word
  a_r3_pass_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass_o |-> (resv_valid_w && req_hit_w));

  // R7: a foreign store to the reserved word ends it
  a_r7_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_we_i && snoop_hit_w && op_w != OP_LL) |=> !resv_valid_w);

  // R8: exceptions end the reservation
  a_r8_exc_kills: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> !resv_valid_w);

  // R9: context switches end the reservation
  a_r9_ctx_kills: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_sw_i |=> !resv_valid_w);

  // R6: a plain local store ends the reservation
  a_r6_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w == OP_ST) |=> !resv_valid_w);

endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] addr_i = '0;
  logic        snoop_we_i = 1'b0;
  logic [31:0] snoop_addr_i = '0;
  logic        exc_i = 1'b0;
  logic        ctx_sw_i = 1'b0;
  logic        sc_pass_o;
  logic        sc_we_o;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  resv_monitor uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i),
    .snoop_we_i(snoop_we_i), .snoop_addr_i(snoop_addr_i),
    .exc_i(exc_i), .ctx_sw_i(ctx_sw_i),
    .sc_pass_o(sc_pass_o), .sc_we_o(sc_we_o)
  );

  localparam logic [1:0] ALU = 2'b00, LL = 2'b01, SC = 2'b10, ST = 2'b11;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic        snp;
    logic [31:0] sa;
    logic        exc;
    logic        ctx;
    logic        pass;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{SC,  32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd1 },  // R1 nothing reserved
    '{LL,  32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},  // R12
    '{ALU, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd10},  // R10
    '{SC,  32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 8'd2 },  // R2 clean pair
    '{SC,  32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd5 },  // R5 consumed
    '{LL,  32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h204, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd3 },  // R3 next word
    '{LL,  32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h203, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 8'd4 },  // R4 offset ignored
    '{LL,  32'h300, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{ST,  32'h900, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h300, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd6 },  // R6 local store
    '{LL,  32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{ALU, 32'h0,   1'b1, 32'h500, 1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 8'd7 },  // R7 other word
    '{LL,  32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{ALU, 32'h0,   1'b1, 32'h402, 1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd7 },  // R7 same word
    '{LL,  32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{ALU, 32'h0,   1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd8 },  // R8 exception
    '{LL,  32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{ALU, 32'h0,   1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 8'd12},
    '{SC,  32'h600, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd9 },  // R9 context switch
    '{LL,  32'h700, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{LL,  32'h800, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h700, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd11},  // R11 replaced
    '{LL,  32'h800, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h800, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 8'd13},  // R13 exc with SC
    '{LL,  32'h800, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'h800, 1'b1, 32'h800, 1'b0, 1'b0, 1'b0, 8'd13},  // R13 snoop with SC
    '{LL,  32'h900, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 8'd12},
    '{SC,  32'h900, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd13},  // R13 ctx with LL
    '{LL,  32'hA00, 1'b1, 32'hA00, 1'b0, 1'b0, 1'b0, 8'd12},
    '{SC,  32'hA00, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 8'd13},  // R13 LL beats snoop
    '{LL,  32'hB00, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd12},
    '{ALU, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 8'd10},
    '{SC,  32'hB00, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 8'd10}   // R10 survives ALU
  };

  task automatic check(input int rq, input logic exp_pass, input string what);
    n_run++;
    if (sc_pass_o !== exp_pass) begin
      n_bad++;
      $display("FAIL R%0d %s: sc_pass_o=%b expected %b", rq, what, sc_pass_o, exp_pass);
    end
    n_run++;
    if (sc_we_o !== exp_pass) begin  // R12 write enable tracks result
      n_bad++;
      $display("FAIL R%0d %s: sc_we_o=%b expected %b", rq, what, sc_we_o, exp_pass);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] a, input logic snp,
                       input logic [31:0] sa, input logic exc, input logic ctx);
    @(negedge clk);
    op_i = op; addr_i = a; snoop_we_i = snp; snoop_addr_i = sa;
    exc_i = exc; ctx_sw_i = ctx;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, "outputs during reset");  // R1
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].a, VEC[i].snp, VEC[i].sa, VEC[i].exc, VEC[i].ctx);
      check(int'(VEC[i].rq), VEC[i].pass, $sformatf("vector %0d", i));
    end

    // R1: reset in the middle of a reservation
    drive(LL, 32'hC00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(ALU, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(SC, 32'hC00, 1'b0, 32'h0, 1'b0, 1'b0);
    check(1, 1'b0, "SC after mid-run reset");

    // R4: high address bits still matter
    drive(LL, 32'h8000_0D00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(SC, 32'h0000_0D00, 1'b0, 32'h0, 1'b0, 1'b0);
    check(4, 1'b0, "SC differing in top bit");

    // R6: store to the reserved word itself also clears
    drive(LL, 32'hE00, 1'b0, 32'h0, 1'b0, 1'b0);
    drive(ST, 32'hE00, 1'b0, 32'h0, 1'b0, 1'b0);
    check(12, 1'b0, "plain store cycle");
    drive(SC, 32'hE00, 1'b0, 32'h0, 1'b0, 1'b0);
    check(6, 1'b0, "SC after same-word store");

    // R10: long run of register ops
    drive(LL, 32'hF04, 1'b0, 32'h0, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) drive(ALU, 32'(k), 1'b0, 32'h0, 1'b0, 1'b0);
    drive(SC, 32'hF07, 1'b0, 32'h0, 1'b0, 1'b0);
    check(10, 1'b1, "SC after 20 register ops");

    drive(ALU, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule